// File: doc/BRIEF.md
# Low-Transition Don't-Care Filler

This block turns a partly specified test vector into a fully specified one while keeping the number of value changes between neighbouring positions as low as possible. The vector arrives as two words of equal width. One is the value word. The other is the care mask, in which a cleared bit marks a position whose value is free (an X). Every free position is resolved to a defined 0 or 1. The block returns the filled vector together with the number of neighbouring position pairs whose values differ in it.

The fill is purely combinational, with a single register stage at the output. A one-cycle `start` pulse captures the result of the current inputs. One cycle later `done` is high for exactly one cycle, and the filled vector and its transition count are valid. Both stay held until the next `start`.

Position numbering: bit index 0 of every vector word is the first (leftmost) position, and bit index N-1 is the last. "Left" means a lower index.

Top module: `xfill_lowtrans`

## Requirements
- R1: Every position whose care bit is set appears in `fill_out` with exactly its `val_in` value.
- R2: A free position that has at least one specified position to its left takes the value of the nearest specified position to its left. Consequences of this rule: a free position between two equal specified neighbours adds no transition, one between differing neighbours copies the left one, and a free run at the right end copies the last specified value.
- R3: A free position with no specified position to its left takes the value of the nearest specified position to its right.
- R4: When the care mask is all zeros, `fill_out` is all zeros and `trans_out` is 0.
- R5: `trans_out` equals the number of index pairs (i, i+1), for i from 0 to N-2, whose filled values differ. This number equals the smallest transition count over every possible filling of the free positions.
- R6: A `start` sampled high at a rising edge makes `done` high after that edge. `done` is low after any edge at which `start` was low, so each start gives a one-cycle pulse.
- R7: Between starts, `fill_out` and `trans_out` hold their values, whatever `val_in` and `care_in` do.
- R8: While the active-high synchronous `rst` is sampled high, `done`, `fill_out` and `trans_out` are cleared to 0, and `start` is ignored.
- R9: For N=8, the five-position vector 1X10X (positions 0..4), followed by free positions 5..7, fills to 11100000. As words, `val_in`=8'h05 and `care_in`=8'h0D give `fill_out`=8'h07 and `trans_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture request for the current inputs |
| val_in | input | N | Value word; bit 0 is the first position |
| care_in | input | N | Care mask; 1 = specified, 0 = free |
| done | output | 1 | One-cycle pulse: outputs are valid |
| fill_out | output | N | Filled vector |
| trans_out | output | $clog2(N) | Transitions between neighbouring filled positions |

## Verification
Directed vectors separate the cases the fill rule treats differently. A fully specified word checks pass-through. An all-free word checks the zero default. A single specified bit at the far right makes a leading free run copy from the right. The 1X10X case combines an interior free bit with equal neighbours and a trailing free run. Alternating fully specified bits give the largest count. Random words with dense and sparse masks mix interior runs, runs with differing neighbours and runs at both ends. For every vector, the count is compared with an exhaustive search over all fillings, which confirms that the minimum is reached and not just some consistent fill. Input changes made without a start confirm that the held outputs do not move.

// File: rtl/xfill_pkg.sv
package xfill_pkg;

    // Direction in which a nearest-specified-value chain is propagated.
    typedef enum logic {
        SCAN_FROM_LEFT  = 1'b0,
        SCAN_FROM_RIGHT = 1'b1
    } scan_dir_e;

    // Width needed for a count of 0 .. n-1.
    function automatic int cnt_w(input int n);
        return (n < 3) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xfill_scan.sv
// Propagates, for each position, the value of the nearest specified position
// in one direction (inclusive of the position itself), plus a flag saying
// whether any specified position was seen on that side.
module xfill_scan
    import xfill_pkg::*;
#(
    parameter int        N   = 8,
    parameter scan_dir_e DIR = SCAN_FROM_LEFT
) (
    input  logic [N-1:0] val,
    input  logic [N-1:0] care,
    output logic [N-1:0] near_val,
    output logic [N-1:0] seen
);

    generate
        if (DIR == SCAN_FROM_LEFT) begin : g_left
            always_comb begin
                logic [N-1:0] v;
                logic [N-1:0] s;
                v = '0;
                s = '0;
                v[0] = care[0] & val[0];
                s[0] = care[0];
                for (int i = 1; i < N; i++) begin
                    v[i] = care[i] ? val[i] : v[i-1];
                    s[i] = care[i] | s[i-1];
                end
                near_val = v;
                seen     = s;
            end
        end else begin : g_right
            always_comb begin
                logic [N-1:0] v;
                logic [N-1:0] s;
                v = '0;
                s = '0;
                v[N-1] = care[N-1] & val[N-1];
                s[N-1] = care[N-1];
                for (int i = N - 2; i >= 0; i--) begin
                    v[i] = care[i] ? val[i] : v[i+1];
                    s[i] = care[i] | s[i+1];
                end
                near_val = v;
                seen     = s;
            end
        end
    endgenerate

endmodule

// File: rtl/xfill_tcount.sv
// Counts neighbouring position pairs with differing values.
module xfill_tcount #(
    parameter int N  = 8,
    parameter int CW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] trans
);

    logic [N-2:0] edges;

    always_comb begin
        int acc;
        edges = vec[N-1:1] ^ vec[N-2:0];
        acc   = 0;
        for (int i = 0; i < N - 1; i++) begin
            acc = acc + int'(edges[i]);
        end
        trans = CW'(acc);
    end

endmodule

// File: rtl/xfill_lowtrans.sv
module xfill_lowtrans
    import xfill_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [N-1:0]          val_in,
    input  logic [N-1:0]          care_in,
    output logic                  done,
    output logic [N-1:0]          fill_out,
    output logic [cnt_w(N)-1:0]   trans_out
);

    localparam int CW = cnt_w(N);

    typedef struct packed {
        logic [N-1:0]  vec;
        logic [CW-1:0] trans;
    } fill_res_t;

    logic [N-1:0] left_val, left_seen;
    logic [N-1:0] right_val, right_seen;
    fill_res_t    res_c;
    fill_res_t    res_q;
    logic         done_q;

    xfill_scan #(.N(N), .DIR(SCAN_FROM_LEFT)) u_scan_left (
        .val      (val_in),
        .care     (care_in),
        .near_val (left_val),
        .seen     (left_seen)
    );

    xfill_scan #(.N(N), .DIR(SCAN_FROM_RIGHT)) u_scan_right (
        .val      (val_in),
        .care     (care_in),
        .near_val (right_val),
        .seen     (right_seen)
    );

    // Nearest left value wins; a leading free run takes the first value on the
    // right, which defaults to 0 when nothing is specified.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            res_c.vec[i] = left_seen[i] ? left_val[i] : right_val[i];
        end
    end

    xfill_tcount #(.N(N), .CW(CW)) u_tcount (
        .vec   (res_c.vec),
        .trans (res_c.trans)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                res_q <= res_c;
            end
        end
    end

    assign done      = done_q;
    assign fill_out  = res_q.vec;
    assign trans_out = res_q.trans;

    AST_CARE_KEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> (((fill_out ^ $past(val_in)) & $past(care_in)) == '0)); // R1

    AST_ALL_FREE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && $past(care_in) == '0) |-> (fill_out == '0 && trans_out == '0)); // R4

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(trans_out) <= int'($countones($past(care_in))))); // R5

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R6

    AST_DONE_ONLY_START: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done); // R6

    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(fill_out) && $stable(trans_out))); // R7

endmodule

// File: tb/xfill_lowtrans_bench.sv
module xfill_lowtrans_bench;

    localparam int N  = 8;
    localparam int CW = xfill_pkg::cnt_w(N);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [N-1:0]  val_in;
    logic [N-1:0]  care_in;
    logic          done;
    logic [N-1:0]  fill_out;
    logic [CW-1:0] trans_out;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    xfill_lowtrans #(.N(N)) u_xfill_lowtrans (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .val_in    (val_in),
        .care_in   (care_in),
        .done      (done),
        .fill_out  (fill_out),
        .trans_out (trans_out)
    );

    // Reference: search outward for the nearest specified neighbour.
    function automatic logic [N-1:0] ref_fill(input logic [N-1:0] v, input logic [N-1:0] c);
        logic [N-1:0] r;
        bit found;
        r = '0;
        for (int i = 0; i < N; i++) begin
            found = 0;
            if (c[i]) begin
                r[i] = v[i];
                found = 1;
            end
            for (int j = i - 1; j >= 0 && !found; j--) begin
                if (c[j]) begin r[i] = v[j]; found = 1; end
            end
            for (int j = i + 1; j < N && !found; j++) begin
                if (c[j]) begin r[i] = v[j]; found = 1; end
            end
        end
        return r;
    endfunction

    function automatic int count_trans(input logic [N-1:0] x);
        int t;
        t = 0;
        for (int i = 0; i + 1 < N; i++) t += (x[i] != x[i+1]) ? 1 : 0;
        return t;
    endfunction

    function automatic int brute_min(input logic [N-1:0] v, input logic [N-1:0] c);
        int best;
        int t;
        logic [N-1:0] cand;
        best = N;
        for (int m = 0; m < (1 << N); m++) begin
            cand = (v & c) | (N'(m) & ~c);
            t = count_trans(cand);
            if (t < best) best = t;
        end
        return best;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [N-1:0] v, input logic [N-1:0] c, input string tag);
        logic [N-1:0] exp_fill;
        string rq;
        exp_fill = ref_fill(v, c);
        if (c == '0) rq = "R4";
        else if (!c[0]) rq = "R3";
        else rq = "R2";
        if (tag != "") rq = tag;
        start   = 1'b1;
        val_in  = v;
        care_in = c;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R6", "done after start", longint'(done), 1);
        chk(((fill_out ^ v) & c) == '0, "R1", "specified bits kept", longint'(fill_out), longint'(v));
        chk(fill_out == exp_fill, rq, "filled vector", longint'(fill_out), longint'(exp_fill));
        chk(int'(trans_out) == count_trans(exp_fill), "R5", "transition count",
            longint'(trans_out), longint'(count_trans(exp_fill)));
        chk(int'(trans_out) == brute_min(v, c), "R5", "count is minimum",
            longint'(trans_out), longint'(brute_min(v, c)));
        @(negedge clk);
        chk(done == 1'b0, "R6", "done single cycle", longint'(done), 0);
    endtask

    task automatic hold_check();
        logic [N-1:0]  f0;
        logic [CW-1:0] t0;
        f0 = fill_out;
        t0 = trans_out;
        val_in  = ~val_in;
        care_in = N'($urandom);
        @(negedge clk);
        @(negedge clk);
        chk(fill_out == f0 && trans_out == t0, "R7", "held without start",
            longint'(fill_out), longint'(f0));
        chk(done == 1'b0, "R7", "no done without start", longint'(done), 0);
    endtask

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] rv, rc;
        void'($urandom(32'd20240611));
        rst     = 1'b1;
        start   = 1'b0;
        val_in  = '0;
        care_in = '0;
        repeat (2) @(negedge clk);
        // start during reset must be ignored
        start   = 1'b1;
        val_in  = 8'hFF;
        care_in = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8", "done in reset", longint'(done), 0);
        chk(fill_out == '0, "R8", "fill in reset", longint'(fill_out), 0);
        chk(trans_out == '0, "R8", "count in reset", longint'(trans_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R8", "done after reset", longint'(done), 0);

        // R9: 1X10X then XXX -> 11100000
        run_vec(8'h05, 8'h0D, "R9");
        chk(fill_out == 8'h07 && trans_out == CW'(1), "R9", "worked example",
            longint'(fill_out), 64'h07);
        hold_check();
        // R4: all free
        run_vec(8'hA5, 8'h00, "R4");
        // R1: fully specified
        run_vec(8'h3C, 8'hFF, "R1");
        // alternating, maximum count
        run_vec(8'h55, 8'hFF, "R5");
        // R3: only last position specified
        run_vec(8'h80, 8'h80, "R3");
        // R2: differing neighbours around a free run -> copies left
        run_vec(8'h80, 8'h81, "R2");
        chk(fill_out == 8'h80, "R2", "differing neighbours copy left",
            longint'(fill_out), 64'h80);
        // R3: leading run then value 1 at position 3
        run_vec(8'h08, 8'h08, "R3");
        chk(fill_out == 8'hFF, "R3", "leading run from right",
            longint'(fill_out), 64'hFF);
        hold_check();

        for (int k = 0; k < 300; k++) begin
            rv = N'($urandom);
            rc = (k % 2 == 0) ? N'($urandom) : N'($urandom & $urandom);
            run_vec(rv, rc, "");
            if (k % 25 == 0) hold_check();
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule